// File: doc/BRIEF.md
# Serial Memory Write-Protection Controller

This block keeps the volatile and nonvolatile protection state of a small serial EEPROM and decides, one instruction at a time, whether a write may start. It holds a write-enable latch, a user flag, a two-bit block-lock field and a write-protect-enable bit. It combines these with an active-low write-protect pin and with the write-in-progress signal from the array engine. It presents the result as a status byte and as two grant strobes, one for the status register and one for the array.

The serial front end decodes each instruction. When chip select rises, it presents the instruction as a one-cycle `op_valid_i` pulse with a code. `cs_ok_i` tells whether chip select rose at a legal bit count. The array engine raises `wip_i` for the length of a nonvolatile cycle once a grant has been given. New block-lock and protect-enable values are held pending and are written into the status byte only when that cycle ends.

Top module: `wp_guard`

## Requirements
- R1: After reset the status byte reads 0x00 while `wip_i` is low, and both grant outputs are low. Status bits 6:5 always read 0.
- R2: Code 1 (write-enable set) with `cs_ok_i`=1 sets status bit 1. With `cs_ok_i`=0 it has no effect. Every code is ignored when `cs_ok_i`=0.
- R3: Code 2 (write-enable clear) clears status bit 1.
- R4: Code 3 sets the flag in status bit 4, and code 4 clears it.
- R5: Code 6 (array write) gives a one-cycle `arr_grant_o` when status bit 1 is set, the block is idle and `addr_i` is not protected. With the block-lock field in status bits 3:2, `addr_prot_o` is high as follows: never for 00, from 0xC00 upward for 01, from 0x800 upward for 10, and everywhere for 11.
- R6: An array write to a protected address gets no grant and clears status bit 1.
- R7: Code 5 (status write) is refused when status bit 7 is 1 and `wp_n_i` is 0. A refusal clears status bit 1. When status bit 7 is 0, the pin level does not matter.
- R8: A status write whose data bits 1:0 are not 00 is refused and clears status bit 1.
- R9: A granted status write takes data bit 7 as the protect enable and bits 3:2 as the block-lock field. These values appear in the status byte only when the cycle ends (`wip_i` falls). A pin change while the cycle runs does not cancel it.
- R10: Status bit 1 clears when any nonvolatile cycle ends. If a write-enable set arrives in that same cycle, the latch ends up set.
- R11: An array or status write is ignored, with no grant and no change to status bit 1, if the write-enable latch is clear, if `cs_ok_i` is 0, or while the block is busy. Status bit 0 shows busy, which is `wip_i` or a pending status write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid_i | input | 1 | One-cycle strobe for a decoded instruction |
| op_code_i | input | 3 | Instruction code: 1 wen set, 2 wen clear, 3 flag set, 4 flag clear, 5 status write, 6 array write |
| cs_ok_i | input | 1 | Chip select rose at a legal bit count |
| sr_data_i | input | 8 | Data byte of a status write |
| addr_i | input | 12 | Address of an array write |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wip_i | input | 1 | Nonvolatile cycle running in the array engine |
| status_o | output | 8 | Status byte |
| addr_prot_o | output | 1 | `addr_i` falls in the locked range |
| sr_grant_o | output | 1 | Status write may start |
| arr_grant_o | output | 1 | Array write may start |

## Verification
Two events can fall in the same cycle: the end of a nonvolatile cycle, which clears the write-enable latch, and a new write-enable set instruction. The bench drops `wip_i` on the same falling edge where it presents the set instruction. It then expects status bit 1 to read 1. A second run drops `wip_i` with no instruction, and there bit 1 must read 0. A second overlap also gets tested: the pin falls while a status write is still running. That write must still commit, and the status write that follows must be refused.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  typedef enum logic [2:0] {
    OP_IDLE     = 3'd0,
    OP_WEN_SET  = 3'd1,
    OP_WEN_CLR  = 3'd2,
    OP_FLAG_SET = 3'd3,
    OP_FLAG_CLR = 3'd4,
    OP_SR_WR    = 3'd5,
    OP_ARR_WR   = 3'd6,
    OP_RSVD     = 3'd7
  } op_e;

  localparam int SB_W    = 8;
  localparam int SB_BUSY = 0;
  localparam int SB_WEN  = 1;
  localparam int SB_BLK  = 2;
  localparam int SB_FLAG = 4;
  localparam int SB_LOCK = 7;

  localparam logic [SB_W-1:0] NV_MASK = 8'h8C;

  function automatic logic sr_locked(input logic lock_en, input logic wp_n);
    return lock_en & ~wp_n;
  endfunction

  function automatic logic sr_data_bad(input logic [SB_W-1:0] d);
    return d[1:0] != 2'b00;
  endfunction

endpackage

// File: rtl/wpg_judge.sv
module wpg_judge
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              op_valid,
  input  op_e               op,
  input  logic              cs_ok,
  input  logic              busy,
  input  logic              wen,
  input  logic [1:0]        blk,
  input  logic              lock_en,
  input  logic              wp_n,
  input  logic [SB_W-1:0]   sr_data,
  input  logic [ADDR_W-1:0] addr,
  output logic              addr_prot,
  output logic              arr_grant,
  output logic              sr_grant,
  output logic              refuse,
  output logic              wen_set,
  output logic              wen_clr,
  output logic              flag_set,
  output logic              flag_clr
);

  localparam logic [ADDR_W-1:0] QTR_BASE  = ADDR_W'(3) << (ADDR_W - 2);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);

  function automatic logic in_locked(input logic [1:0] b, input logic [ADDR_W-1:0] a);
    case (b)
      2'b00:   return 1'b0;
      2'b01:   return a >= QTR_BASE;
      2'b10:   return a >= HALF_BASE;
      default: return 1'b1;
    endcase
  endfunction

  logic qualified;
  logic try_arr;
  logic try_sr;
  logic sr_bad;

  always_comb begin
    qualified = op_valid & cs_ok;
    addr_prot = in_locked(blk, addr);
    wen_set   = qualified && (op == OP_WEN_SET);
    wen_clr   = qualified && (op == OP_WEN_CLR);
    flag_set  = qualified && (op == OP_FLAG_SET);
    flag_clr  = qualified && (op == OP_FLAG_CLR);
    try_arr   = qualified && (op == OP_ARR_WR) && wen && !busy;
    try_sr    = qualified && (op == OP_SR_WR) && wen && !busy;
    sr_bad    = sr_locked(lock_en, wp_n) | sr_data_bad(sr_data);
    arr_grant = try_arr & ~addr_prot;
    sr_grant  = try_sr & ~sr_bad;
    refuse    = (try_arr & addr_prot) | (try_sr & sr_bad);
  end

endmodule

// File: rtl/wpg_latches.sv
module wpg_latches (
  input  logic clk,
  input  logic rst_n,
  input  logic wen_set,
  input  logic wen_clr,
  input  logic refuse,
  input  logic nv_done,
  input  logic flag_set,
  input  logic flag_clr,
  output logic wen,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen <= 1'b0;
    end else if (wen_set) begin
      wen <= 1'b1;
    end else if (wen_clr || refuse || nv_done) begin
      wen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
    end else if (flag_set) begin
      flag <= 1'b1;
    end else if (flag_clr) begin
      flag <= 1'b0;
    end
  end

endmodule

// File: rtl/wpg_nvregs.sv
module wpg_nvregs
  import wpg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sr_grant,
  input  logic [SB_W-1:0] sr_data,
  input  logic            nv_done,
  output logic [1:0]      blk,
  output logic            lock_en,
  output logic            pending,
  output logic            commit
);

  logic [SB_W-1:0] held_q;
  logic [SB_W-1:0] live_q;

  assign commit  = nv_done & pending;
  assign blk     = live_q[SB_BLK +: 2];
  assign lock_en = live_q[SB_LOCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q  <= '0;
      pending <= 1'b0;
    end else if (sr_grant) begin
      held_q  <= sr_data & NV_MASK;
      pending <= 1'b1;
    end else if (nv_done) begin
      pending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (commit) begin
      live_q <= held_q;
    end
  end

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid_i,
  input  logic [2:0]        op_code_i,
  input  logic              cs_ok_i,
  input  logic [7:0]        sr_data_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wp_n_i,
  input  logic              wip_i,
  output logic [7:0]        status_o,
  output logic              addr_prot_o,
  output logic              sr_grant_o,
  output logic              arr_grant_o
);

  logic       wip_q;
  logic       nv_done_w;
  logic       busy_w;
  logic       wen_w;
  logic       flag_w;
  logic [1:0] blk_w;
  logic       lock_en_w;
  logic       pending_w;
  logic       commit_w;
  logic       refuse_w;
  logic       wen_set_w;
  logic       wen_clr_w;
  logic       flag_set_w;
  logic       flag_clr_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wip_q <= 1'b0;
    else        wip_q <= wip_i;
  end

  assign nv_done_w = wip_q & ~wip_i;
  assign busy_w    = wip_i | pending_w;

  wpg_judge #(.ADDR_W(ADDR_W)) u_judge (
    .op_valid  (op_valid_i),
    .op        (op_e'(op_code_i)),
    .cs_ok     (cs_ok_i),
    .busy      (busy_w),
    .wen       (wen_w),
    .blk       (blk_w),
    .lock_en   (lock_en_w),
    .wp_n      (wp_n_i),
    .sr_data   (sr_data_i),
    .addr      (addr_i),
    .addr_prot (addr_prot_o),
    .arr_grant (arr_grant_o),
    .sr_grant  (sr_grant_o),
    .refuse    (refuse_w),
    .wen_set   (wen_set_w),
    .wen_clr   (wen_clr_w),
    .flag_set  (flag_set_w),
    .flag_clr  (flag_clr_w)
  );

  wpg_latches u_latches (
    .clk      (clk),
    .rst_n    (rst_n),
    .wen_set  (wen_set_w),
    .wen_clr  (wen_clr_w),
    .refuse   (refuse_w),
    .nv_done  (nv_done_w),
    .flag_set (flag_set_w),
    .flag_clr (flag_clr_w),
    .wen      (wen_w),
    .flag     (flag_w)
  );

  wpg_nvregs u_nvregs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sr_grant (sr_grant_o),
    .sr_data  (sr_data_i),
    .nv_done  (nv_done_w),
    .blk      (blk_w),
    .lock_en  (lock_en_w),
    .pending  (pending_w),
    .commit   (commit_w)
  );

  always_comb begin
    status_o                 = '0;
    status_o[SB_BUSY]        = busy_w;
    status_o[SB_WEN]         = wen_w;
    status_o[SB_BLK +: 2]    = blk_w;
    status_o[SB_FLAG]        = flag_w;
    status_o[SB_LOCK]        = lock_en_w;
  end

endmodule

// File: rtl/wpg_chk.sv
module wpg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] status,
  input logic       sr_grant,
  input logic       arr_grant,
  input logic       addr_prot,
  input logic       wp_n,
  input logic [1:0] sr_low,
  input logic       wen_set,
  input logic       refuse,
  input logic       nv_done,
  input logic       commit
);

  // R1
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[6:5] == 2'b00);

  // R2
  wen_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wen_set |=> status[1]);

  // R5
  arr_permit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant |-> (status[1] && !addr_prot && !status[0]));

  // R6
  refuse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refuse |=> !status[1]);

  // R7
  sr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant |-> !(status[7] && !wp_n));

  // R8
  sr_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant |-> (sr_low == 2'b00));

  // R9
  nv_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(status[7]) || !$stable(status[3:2])) |-> $past(commit));

  // R10
  done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_done && !wen_set) |=> !status[1]);

  // R11
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sr_grant && arr_grant));

endmodule

bind wp_guard wpg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .status    (status_o),
  .sr_grant  (sr_grant_o),
  .arr_grant (arr_grant_o),
  .addr_prot (addr_prot_o),
  .wp_n      (wp_n_i),
  .sr_low    (sr_data_i[1:0]),
  .wen_set   (wen_set_w),
  .refuse    (refuse_w),
  .nv_done   (nv_done_w),
  .commit    (commit_w)
);

// File: tb/tb_wp_guard.sv
module tb_wp_guard;

  localparam logic [2:0] C_WSET = 3'd1, C_WCLR = 3'd2, C_FSET = 3'd3,
                         C_FCLR = 3'd4, C_SRWR = 3'd5, C_ARWR = 3'd6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = 3'd0;
  logic        cs_ok = 1'b0;
  logic [7:0]  sr_data = 8'h00;
  logic [11:0] addr = 12'h000;
  logic        wp_n = 1'b1;
  logic        wip = 1'b0;
  logic [7:0]  status;
  logic        addr_prot, sr_grant, arr_grant;
  logic        g_sr, g_arr;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  wp_guard dut (
    .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
    .cs_ok_i(cs_ok), .sr_data_i(sr_data), .addr_i(addr), .wp_n_i(wp_n),
    .wip_i(wip), .status_o(status), .addr_prot_o(addr_prot),
    .sr_grant_o(sr_grant), .arr_grant_o(arr_grant)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [2:0] code, input logic ok,
                       input logic [7:0] d, input logic [11:0] a);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; cs_ok = ok; sr_data = d; addr = a;
    #1;
    g_sr = sr_grant; g_arr = arr_grant;
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd0; cs_ok = 1'b0;
  endtask

  task automatic nv_cycle();
    wip = 1'b1;
    repeat (3) @(negedge clk);
    wip = 1'b0;
    @(negedge clk);
  endtask

  task automatic prot_at(input logic [11:0] a, input logic exp, input string req);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, {7'd0, addr_prot}, {7'd0, exp});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", status, 8'h00);
    chk("R1 grants", {6'd0, sr_grant, arr_grant}, 8'h00);
  endtask

  task automatic t_latches();
    issue(C_WSET, 1'b0, 8'h00, 12'h000);
    chk("R2 no qualifier", status, 8'h00);
    issue(C_WSET, 1'b1, 8'h00, 12'h000);
    chk("R2 set", status, 8'h02);
    issue(C_WCLR, 1'b1, 8'h00, 12'h000);
    chk("R3 clear", status, 8'h00);
    issue(C_FSET, 1'b1, 8'h00, 12'h000);
    chk("R4 flag set", status, 8'h10);
    issue(C_FCLR, 1'b1, 8'h00, 12'h000);
    chk("R4 flag clear", status, 8'h00);
  endtask

  task automatic t_array();
    issue(C_ARWR, 1'b1, 8'h00, 12'h100);
    chk("R11 no wen grant", {7'd0, g_arr}, 8'h00);
    issue(C_WSET, 1'b1, 8'h00, 12'h000);
    issue(C_ARWR, 1'b0, 8'h00, 12'h100);
    chk("R11 no qualifier grant", {7'd0, g_arr}, 8'h00);
    chk("R11 wen kept", status, 8'h02);
    @(negedge clk); wip = 1'b1;
    issue(C_ARWR, 1'b1, 8'h00, 12'h100);
    chk("R11 busy grant", {7'd0, g_arr}, 8'h00);
    chk("R11 busy status", status, 8'h03);
    @(negedge clk); wip = 1'b0;
    @(negedge clk);
    chk("R10 done clears wen", status, 8'h00);
    issue(C_WSET, 1'b1, 8'h00, 12'h000);
    issue(C_ARWR, 1'b1, 8'h00, 12'hFFF);
    chk("R5 grant bl00", {7'd0, g_arr}, 8'h01);
    wip = 1'b1;
    repeat (3) @(negedge clk);
    wip = 1'b0;
    op_valid = 1'b1; op_code = C_WSET; cs_ok = 1'b1;
    @(negedge clk);
    op_valid = 1'b0; op_code = 3'd0; cs_ok = 1'b0;
    chk("R10 same-cycle set wins", status, 8'h02);
  endtask

  task automatic t_status();
    issue(C_SRWR, 1'b1, 8'h8D, 12'h000);
    chk("R8 bad data grant", {7'd0, g_sr}, 8'h00);
    chk("R8 refuse clears wen", status, 8'h00);
    issue(C_WSET, 1'b1, 8'h00, 12'h000);
    issue(C_SRWR, 1'b1, 8'h8C, 12'h000);
    chk("R9 grant", {7'd0, g_sr}, 8'h01);
    chk("R9 pending not visible", status, 8'h03);
    wip = 1'b1;
    @(negedge clk);
    wp_n = 1'b0;
    repeat (2) @(negedge clk);
    wip = 1'b0;
    @(negedge clk);
    chk("R9 committed", status, 8'h8C);
    prot_at(12'h000, 1'b1, "R5 bl11 low");
    issue(C_WSET, 1'b1, 8'h00, 12'h000);
    issue(C_ARWR, 1'b1, 8'h00, 12'h000);
    chk("R6 no grant", {7'd0, g_arr}, 8'h00);
    chk("R6 wen cleared", status, 8'h8C);
    issue(C_WSET, 1'b1, 8'h00, 12'h000);
    issue(C_SRWR, 1'b1, 8'h00, 12'h000);
    chk("R7 locked", {7'd0, g_sr}, 8'h00);
    chk("R7 wen cleared", status, 8'h8C);
    wp_n = 1'b1;
    issue(C_WSET, 1'b1, 8'h00, 12'h000);
    issue(C_SRWR, 1'b1, 8'h04, 12'h000);
    chk("R7 pin high grant", {7'd0, g_sr}, 8'h01);
    nv_cycle();
    chk("R9 bl01", status, 8'h04);
    prot_at(12'hBFF, 1'b0, "R5 bl01 below");
    prot_at(12'hC00, 1'b1, "R5 bl01 at");
    wp_n = 1'b0;
    issue(C_WSET, 1'b1, 8'h00, 12'h000);
    issue(C_SRWR, 1'b1, 8'h08, 12'h000);
    chk("R7 pin ignored", {7'd0, g_sr}, 8'h01);
    nv_cycle();
    prot_at(12'h7FF, 1'b0, "R5 bl10 below");
    prot_at(12'h800, 1'b1, "R5 bl10 at");
    issue(C_WSET, 1'b1, 8'h00, 12'h000);
    issue(C_SRWR, 1'b1, 8'h00, 12'h000);
    nv_cycle();
    prot_at(12'hFFF, 1'b0, "R5 bl00 top");
    chk("R1 final", status, 8'h00);
  endtask

  initial begin
    t_reset();
    t_latches();
    t_array();
    t_status();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule